// File: doc/BRIEF.md
# Prioritized Latched Interrupt Controller

This block takes four external interrupt lines and turns them into requests for a host CPU. A request is raised only when an input has been high for a minimum time. Once raised, a request is held in a per-channel latch until the host clears that channel. A fixed priority encoder then shows the host the single most urgent pending channel. The host clears requests one at a time through a per-channel reset strobe.

Each channel has a 16-bit configuration word, written through a per-channel write strobe. Its low hex digit selects the channel's function. Only channels set to the interrupt function can raise requests; the other functions are handled elsewhere and are simply passed over here. Channel 0 can instead act as a periodic interrupt, with a millisecond interval coded in BCD in the upper three digits of its word.

The block runs from one system clock. Timing comes from a one-cycle enable that pulses once per microsecond.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset, no channel is latched, `irq_pending` is 0, and all four configuration words hold 0x0004, so every channel starts as an external interrupt.
- R2: An input held high for at least 100 microsecond ticks latches its channel within a few cycles of the 100th tick. A high pulse that ends before 100 ticks never latches.
- R3: A request is edge triggered. An input that stays high after its channel has been cleared does not raise a second request until it has gone low and then qualified again.
- R4: A latched channel stays set when its input falls. It clears on the clock edge that samples its bit of `ack_reset` high.
- R5: A qualified pulse that arrives on a channel that is already latched is dropped. It is not queued, so the channel reads clear after the pending request is cleared.
- R6: `irq_pending` is the OR of the latched bits. `irq_id` is the binary number of the lowest-numbered latched channel, so channel 0 beats 1, 1 beats 2, and 2 beats 3. When channels 0 and 1 latch together, 0 is shown first and 1 is shown once 0 is cleared.
- R7: Only a configuration word whose bits [3:0] equal 4 lets a channel latch. The values 5 (pulse catch) and 6 (filtered input, filter time in bits [15:8]) and any other value never set the latch.
- R8: With bits [3:0] = 4 and bits [15:4] nonzero, channel 0 is timed. The interval in ms is the BCD value with hundreds in [15:12], tens in [11:8] and units in [7:4]. The channel latches once per interval, and its external input is ignored.
- R9: A timed interval below 3 ms, or one with any digit above 9, disables channel 0: it raises no request at all.
- R10: Writing channel 0's configuration word restarts the interval count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-cycle enable, once per microsecond |
| irq_in | input | 4 | Asynchronous external interrupt inputs |
| cfg_we | input | 4 | Per-channel configuration write strobe |
| cfg_wdata | input | 16 | Configuration word to write |
| ack_reset | input | 4 | Per-channel latch clear from the host |
| irq_pending | output | 1 | At least one channel latched |
| irq_id | output | 2 | Highest-priority latched channel |
| irq_latched | output | 4 | Latched request per channel |

## Verification
The latch for an external input rises about three cycles after the 100th tick counted from the input's rise. Two of those cycles are the synchronizer and one is the latch itself. A host clear takes effect on the next edge, while `irq_pending` and `irq_id` follow the latch in the same cycle.

A timed request appears one cycle after the last tick of the interval, counted from the configuration write. With ticks every second clock, that is about twice the tick count in clocks. The checks sample on falling edges. They either wait until a pulse is over and the result has settled, or they test a request's timing with a window of several cycles on each side of the due cycle, so that the exact tick phase cannot change any result.

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl #(
  parameter int NCH          = 4,
  parameter int QUAL_TICKS   = 100,
  parameter int TICKS_PER_MS = 1000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_us,
  input  logic [NCH-1:0]         irq_in,
  input  logic [NCH-1:0]         cfg_we,
  input  logic [15:0]            cfg_wdata,
  input  logic [NCH-1:0]         ack_reset,
  output logic                   irq_pending,
  output logic [$clog2(NCH)-1:0] irq_id,
  output logic [NCH-1:0]         irq_latched
);

  localparam int QW  = $clog2(QUAL_TICKS + 1);
  localparam int MW  = $clog2(TICKS_PER_MS + 1);
  localparam int IDW = $clog2(NCH);

  logic [NCH-1:0] sync1, sync2, armed, qual_fire, is_int, set_req;
  logic [15:0]    cfg_q [NCH];
  logic [QW-1:0]  qcnt  [NCH];

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      assign is_int[g] = (cfg_q[g][3:0] == 4'h4);
      assign qual_fire[g] = sync2[g] & armed[g] & tick_us &
                            (qcnt[g] == QW'(QUAL_TICKS - 1));

      always_ff @(posedge clk) begin
        if (!rst_n)         cfg_q[g] <= 16'h0004;
        else if (cfg_we[g]) cfg_q[g] <= cfg_wdata;
      end

      always_ff @(posedge clk) begin
        if (!rst_n || !sync2[g]) begin
          qcnt[g]  <= '0;
          armed[g] <= 1'b1;
        end else if (armed[g] && tick_us) begin
          if (qual_fire[g]) begin
            qcnt[g]  <= '0;
            armed[g] <= 1'b0;
          end else begin
            qcnt[g] <= qcnt[g] + 1'b1;
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= irq_in;
      sync2 <= sync1;
    end
  end

  logic [3:0]    dig_h, dig_t, dig_u;
  logic [9:0]    interval;
  logic          timed_mode, timer_ok, ms_pulse, timer_fire;
  logic [MW-1:0] ms_div;
  logic [9:0]    ms_cnt;

  assign dig_h      = cfg_q[0][15:12];
  assign dig_t      = cfg_q[0][11:8];
  assign dig_u      = cfg_q[0][7:4];
  assign interval   = 10'(dig_h) * 10'd100 + 10'(dig_t) * 10'd10 + 10'(dig_u);
  assign timed_mode = is_int[0] & (|cfg_q[0][15:4]);
  assign timer_ok   = timed_mode & (dig_h <= 4'd9) & (dig_t <= 4'd9) &
                      (dig_u <= 4'd9) & (interval >= 10'd3);
  assign ms_pulse   = tick_us & (ms_div == MW'(TICKS_PER_MS - 1));
  assign timer_fire = timer_ok & ms_pulse & (ms_cnt == interval - 10'd1) & !cfg_we[0];

  always_ff @(posedge clk) begin
    if (!rst_n || cfg_we[0] || !timer_ok) begin
      ms_div <= '0;
      ms_cnt <= '0;
    end else if (tick_us) begin
      if (ms_pulse) begin
        ms_div <= '0;
        ms_cnt <= (ms_cnt == interval - 10'd1) ? 10'd0 : ms_cnt + 10'd1;
      end else begin
        ms_div <= ms_div + 1'b1;
      end
    end
  end

  always_comb begin
    set_req    = qual_fire & is_int;
    set_req[0] = timed_mode ? timer_fire : (qual_fire[0] & is_int[0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_latched <= '0;
    else        irq_latched <= (irq_latched | set_req) & ~ack_reset;
  end

  assign irq_pending = |irq_latched;

  always_comb begin
    irq_id = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (irq_latched[i]) irq_id = IDW'(i);
  end

  assert_lowest_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> (irq_latched[irq_id] &&
                     ((irq_latched & ((NCH'(1) << irq_id) - NCH'(1))) == '0)));

  assert_timer_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_latched[0]) && $past(timed_mode)) |-> $past(timer_ok));

  generate
    for (g = 0; g < NCH; g++) begin : g_chk
      assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_latched[g] && !ack_reset[g]) |=> irq_latched[g]);
      assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_reset[g] |=> !irq_latched[g]);
      assert_func_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_latched[g]) |-> ($past(cfg_q[g][3:0]) == 4'h4));
    end
  endgenerate

endmodule

// File: tb/test_irq_latch_ctrl.sv
module test_irq_latch_ctrl;
  logic clk = 0, rst_n = 0, tick_us = 0;
  logic [3:0] irq_in = 0, cfg_we = 0, ack_reset = 0;
  logic [15:0] cfg_wdata = 0;
  logic irq_pending;
  logic [1:0] irq_id;
  logic [3:0] irq_latched;
  int checks = 0, failures = 0;
  bit done = 0;

  irq_latch_ctrl #(.NCH(4), .QUAL_TICKS(100), .TICKS_PER_MS(5)) i_irq_latch_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .irq_in(irq_in), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .ack_reset(ack_reset), .irq_pending(irq_pending),
    .irq_id(irq_id), .irq_latched(irq_latched));

  always #4 clk = ~clk;

  initial forever begin
    @(negedge clk);
    tick_us = ~tick_us;
  end

  function automatic int lowest(input logic [3:0] v);
    for (int i = 3; i >= 0; i--) if (v[i]) lowest = i;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(input int ch, input logic [15:0] w);
    @(negedge clk);
    cfg_we[ch] = 1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_we[ch] = 0;
  endtask

  task automatic ack(input int ch);
    @(negedge clk);
    ack_reset[ch] = 1;
    @(negedge clk);
    ack_reset[ch] = 0;
  endtask

  task automatic pulse(input int ch, input int dly, input int width);
    wait_n(dly);
    irq_in[ch] = 1;
    wait_n(width);
    irq_in[ch] = 0;
  endtask

  task automatic drain(input string req, input logic [3:0] exp_v);
    logic [3:0] v = exp_v;
    chk(req, irq_latched, v);
    chk(req, irq_pending, int'(v != 0));
    while (v != 0) begin
      chk(req, irq_id, lowest(v));
      ack(lowest(v));
      v[lowest(v)] = 0;
      wait_n(1);
      chk(req, irq_latched, v);
    end
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", wd);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [3:0] exp_v, intm;
    void'($urandom(32'd4242));
    wait_n(5);
    rst_n = 1;
    wait_n(2);
    // R1 reset state and default interrupt function
    chk("R1 latched", irq_latched, 0);
    chk("R1 pending", irq_pending, 0);
    fork
      pulse(0, 0, 240); pulse(1, 3, 240); pulse(2, 7, 240); pulse(3, 1, 240);
    join
    wait_n(20);
    drain("R1 default cfg", 4'hf);

    // R2 threshold timing window and short pulse
    @(negedge clk);
    irq_in[2] = 1;
    wait_n(188);
    chk("R2 before threshold", irq_latched[2], 0);
    wait_n(25);
    chk("R2 after threshold", irq_latched[2], 1);
    // R3 held input after clear does not re-request
    ack(2);
    wait_n(300);
    chk("R3 no retrigger", irq_latched[2], 0);
    irq_in[2] = 0;
    pulse(1, 0, 170);
    wait_n(20);
    chk("R2 short pulse", irq_latched, 0);

    // R4 hold after fall, R5 no queueing
    pulse(3, 0, 240);
    wait_n(50);
    chk("R4 held after fall", irq_latched[3], 1);
    pulse(3, 0, 240);
    wait_n(20);
    ack(3);
    wait_n(5);
    chk("R5 not queued", irq_latched[3], 0);

    // R6 simultaneous channels 0 and 1
    fork pulse(0, 0, 240); pulse(1, 0, 240); join
    wait_n(20);
    chk("R6 id first", irq_id, 0);
    ack(0);
    wait_n(1);
    chk("R6 id second", irq_id, 1);
    chk("R6 pending", irq_pending, 1);
    ack(1);
    wait_n(1);
    chk("R6 none", irq_pending, 0);

    // R7 non-interrupt functions
    write_cfg(3, 16'h0005);
    write_cfg(2, 16'h1006);
    fork pulse(2, 0, 240); pulse(3, 0, 240); join
    wait_n(20);
    chk("R7 no latch", irq_latched, 0);

    // random episodes: R2 R6 R7
    for (int ep = 0; ep < 12; ep++) begin
      logic [3:0] longm = 0;
      int kind[4], dl[4], wd_[4];
      for (int c = 0; c < 4; c++) begin
        int r = $urandom % 4;
        logic [15:0] w = (r == 3) ? 16'h2006 : (r == 2 && c != 0) ? 16'h0005 : 16'h0004;
        write_cfg(c, w);
        intm[c] = (w[3:0] == 4'h4);
        kind[c] = $urandom % 3;
        dl[c] = $urandom % 50;
        wd_[c] = (kind[c] == 2) ? 230 + $urandom % 170 : 10 + $urandom % 160;
        longm[c] = (kind[c] == 2);
      end
      fork
        if (kind[0] != 0) pulse(0, dl[0], wd_[0]);
        if (kind[1] != 0) pulse(1, dl[1], wd_[1]);
        if (kind[2] != 0) pulse(2, dl[2], wd_[2]);
        if (kind[3] != 0) pulse(3, dl[3], wd_[3]);
      join
      wait_n(20);
      exp_v = longm & intm;
      drain("R6 R7 random", exp_v);
    end

    // R8 timed interrupt, 3 ms = 15 ticks = 30 cycles
    write_cfg(0, 16'h0034);
    wait_n(23);
    chk("R8 before interval", irq_latched[0], 0);
    wait_n(12);
    chk("R8 at interval", irq_latched[0], 1);
    ack(0);
    wait_n(16);
    chk("R8 between", irq_latched[0], 0);
    wait_n(12);
    chk("R8 second period", irq_latched[0], 1);
    ack(0);
    // R10 rewrite restarts count
    write_cfg(0, 16'h0034);
    wait_n(18);
    write_cfg(0, 16'h0034);
    wait_n(23);
    chk("R10 restart", irq_latched[0], 0);
    wait_n(12);
    chk("R10 after restart", irq_latched[0], 1);
    ack(0);
    // R8 external input ignored in timed mode
    write_cfg(0, 16'h9994);
    pulse(0, 0, 240);
    wait_n(20);
    chk("R8 input ignored", irq_latched[0], 0);
    // R9 invalid intervals
    write_cfg(0, 16'h0024);
    pulse(0, 0, 240);
    wait_n(100);
    chk("R9 below range", irq_latched[0], 0);
    write_cfg(0, 16'h00a4);
    wait_n(200);
    chk("R9 non-BCD", irq_latched[0], 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule